// File: doc/BRIEF.md
# YCbCr-to-RGB Matrix Converter

This block converts a stream of three-component pixels (luma and two chroma values) into red, green and blue, one pixel per clock. Each output channel is a programmable linear combination of the three input components plus an offset, rounded to the nearest integer and saturated to the unsigned output range. A valid flag travels with every pixel through a fixed three-stage pipeline. When a pixel's layer has conversion switched off, the three components are copied through unchanged.

Software fills twelve 32-bit coefficient words and one control word through a single-cycle write port. The control word selects one of two number formats. In the legacy format, factors carry 10 fractional bits, a 32-bit constant is added after the products, and components are 8 bits wide. In the extended format, factors carry 17 fractional bits, and each row's offset word packs an input bias with an output constant; components are 10 bits wide. The control word also holds one conversion-enable bit per layer. Chroma-swapped input (Y, Cr, Cb ordering) needs no extra hardware: software swaps coefficient columns 1 and 2 in every row.

Top module: `ycc_rgb_matrix`

## Requirements
- R1: After reset, `rgb_valid` is 0, the three output components are 0, all coefficient words are 0, every layer enable is clear and the legacy format is selected.
- R2: A pixel presented with `pix_valid` high on clock edge k appears with `rgb_valid` high just after edge k+3. Pixels leave in arrival order, gaps are kept, and no output is produced without an input.
- R3: Address 4n+k (n = 0..2 for R, G, B; k = 0..2) holds the factor that multiplies input component k (`pix_c0`, `pix_c1`, `pix_c2`) for output channel n. Address 4n+3 is that row's offset word. Address 12 is the control word: bit i enables conversion for layer i, and bit 31 selects the extended format when set. Writes to addresses 13 to 15 change nothing.
- R4: Legacy format. Inputs use their low 8 bits. Each output is (c0·x0 + c1·x1 + c2·x2 + K + 512) arithmetically shifted right by 10 and then clamped to 0..255. The factors and K are 32-bit two's complement numbers with 10 fractional bits, and K is the row's full offset word.
- R5: Extended format. Inputs are 10-bit. Offset word 4k+3 bits 31:16 hold a signed bias that is added to input k before any multiplication. Offset word 4n+3 bits 15:0 hold a signed integer constant that is added to output n. Each output is (Σ ck·(xk+dk) + const·2^17 + 2^16) shifted right by 17 and then clamped to 0..1023.
- R6: A result below zero gives 0. A result above the format maximum (255 in legacy, 1023 in extended) gives that maximum.
- R7: When the enable bit for `pix_layer` is clear, the outputs equal `pix_c0`, `pix_c1` and `pix_c2` unchanged (all 10 bits) with the same latency. Pixels of other layers are still converted.
- R8: A register write takes effect from the pixel presented on the cycle after the write. A pixel presented in the same cycle as the write, or already in the pipeline, is computed with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Input pixel valid |
| pix_layer | input | 1 | Layer index of the input pixel |
| pix_c0 | input | 10 | Input component 0 (luma) |
| pix_c1 | input | 10 | Input component 1 (first chroma) |
| pix_c2 | input | 10 | Input component 2 (second chroma) |
| rgb_valid | output | 1 | Output pixel valid |
| rgb_r | output | 10 | Red result |
| rgb_g | output | 10 | Green result |
| rgb_b | output | 10 | Blue result |

## Verification
The bench sweeps ramps of components through four matrices. A mixed-sign legacy matrix drives results into both clamps. Shifted identity rows with offsets of exactly one half and just under one half show the round-half-up rule. An extended matrix with luma and chroma biases shows that the bias is applied before multiplication. Extended identity rows with positive, negative and three-quarter terms isolate the constant and the fractional rounding. Repeating the legacy sweep with columns swapped and inputs swapped confirms which input each column multiplies. Writes placed on the same cycle as a pixel, interleaved with a back-to-back stream, and aimed at unused addresses separate the register timing from the arithmetic. Alternating layers with only one enabled shows passthrough beside live conversion.

// File: rtl/ycc_rgb_pkg.sv
package ycc_rgb_pkg;
    localparam int COEF_W      = 32;
    localparam int NUM_CH      = 3;
    localparam int ROW_WORDS   = 4;
    localparam int NUM_WORDS   = NUM_CH * ROW_WORDS;
    localparam int CTRL_ADDR   = NUM_WORDS;
    localparam int ADDR_W      = $clog2(CTRL_ADDR + 1);
    localparam int LEG_FRAC    = 10;
    localparam int EXT_FRAC    = 17;
    localparam int DIFF_W      = 16;
    localparam int FMT_BIT     = 31;

    typedef enum logic {
        FMT_LEGACY   = 1'b0,
        FMT_EXTENDED = 1'b1
    } fmt_e;
endpackage

// File: rtl/ycc_coef_regs.sv
module ycc_coef_regs
    import ycc_rgb_pkg::*;
#(
    parameter int NUM_LAYERS = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [COEF_W-1:0]                  wdata,
    output logic [NUM_WORDS-1:0][COEF_W-1:0]   coef_o,
    output logic [NUM_LAYERS-1:0]              en_o,
    output fmt_e                               fmt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_o <= '0;
            en_o   <= '0;
            fmt_o  <= FMT_LEGACY;
        end else if (we) begin
            if (addr < ADDR_W'(NUM_WORDS)) begin
                coef_o[addr] <= wdata;
            end else if (addr == ADDR_W'(CTRL_ADDR)) begin
                en_o  <= wdata[NUM_LAYERS-1:0];
                fmt_o <= fmt_e'(wdata[FMT_BIT]);
            end
        end
    end

    AST_COEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr < ADDR_W'(NUM_WORDS)) |=> (coef_o[$past(addr)] == $past(wdata))); // R3
    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr > ADDR_W'(CTRL_ADDR)) |=> ($stable(coef_o) && $stable(en_o) && $stable(fmt_o))); // R3
endmodule

// File: rtl/ycc_rgb_lane.sv
module ycc_rgb_lane
    import ycc_rgb_pkg::*;
#(
    parameter int COMP_W = 10,
    parameter int LEG_W  = 8,
    parameter int ADJ_W  = 18
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               ld0,
    input  logic                               ld1,
    input  logic                               ld2,
    input  fmt_e                               fmt_i,
    input  logic                               byp_i,
    input  logic [COMP_W-1:0]                  pass_i,
    input  logic [NUM_CH-1:0][ADJ_W-1:0]       adj_i,
    input  logic [ROW_WORDS-1:0][COEF_W-1:0]   row_i,
    output logic [COMP_W-1:0]                  res_o
);
    localparam int PROD_W = COEF_W + ADJ_W;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic [COMP_W-1:0] EXT_MAX = '1;
    localparam logic [COMP_W-1:0] LEG_MAX = COMP_W'((1 << LEG_W) - 1);

    // stage 1: products and aligned constant
    logic signed [PROD_W-1:0] prod_d [NUM_CH];
    logic signed [PROD_W-1:0] prod_q [NUM_CH];
    logic signed [SUM_W-1:0]  cst_d, cst_q;
    fmt_e                     fmt1, fmt2;
    logic                     byp1, byp2;
    logic [COMP_W-1:0]        pass1, pass2;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_mul
        assign prod_d[k] = PROD_W'($signed(row_i[k])) * PROD_W'($signed(adj_i[k]));
    end

    always_comb begin
        if (fmt_i == FMT_EXTENDED) begin
            cst_d = SUM_W'($signed(row_i[ROW_WORDS-1][DIFF_W-1:0])) <<< EXT_FRAC;
        end else begin
            cst_d = SUM_W'($signed(row_i[ROW_WORDS-1]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_CH; k++) prod_q[k] <= '0;
            cst_q <= '0;
            fmt1  <= FMT_LEGACY;
            byp1  <= 1'b0;
            pass1 <= '0;
        end else if (ld0) begin
            for (int k = 0; k < NUM_CH; k++) prod_q[k] <= prod_d[k];
            cst_q <= cst_d;
            fmt1  <= fmt_i;
            byp1  <= byp_i;
            pass1 <= pass_i;
        end
    end

    // stage 2: accumulate with rounding term
    logic signed [SUM_W-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = cst_q;
        for (int k = 0; k < NUM_CH; k++) sum_d = sum_d + SUM_W'(prod_q[k]);
        if (fmt1 == FMT_EXTENDED) sum_d = sum_d + SUM_W'(1 << (EXT_FRAC - 1));
        else                      sum_d = sum_d + SUM_W'(1 << (LEG_FRAC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            fmt2  <= FMT_LEGACY;
            byp2  <= 1'b0;
            pass2 <= '0;
        end else if (ld1) begin
            sum_q <= sum_d;
            fmt2  <= fmt1;
            byp2  <= byp1;
            pass2 <= pass1;
        end
    end

    // stage 3: scale, saturate, select
    logic signed [SUM_W-1:0] shifted, lim;
    logic [COMP_W-1:0]       clamped;

    always_comb begin
        if (fmt2 == FMT_EXTENDED) begin
            shifted = sum_q >>> EXT_FRAC;
            lim     = SUM_W'(EXT_MAX);
        end else begin
            shifted = sum_q >>> LEG_FRAC;
            lim     = SUM_W'(LEG_MAX);
        end
        if (shifted < 0)        clamped = '0;
        else if (shifted > lim) clamped = lim[COMP_W-1:0];
        else                    clamped = shifted[COMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   res_o <= '0;
        else if (ld2) res_o <= byp2 ? pass2 : clamped;
    end

    AST_LEGACY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ld2 && fmt2 == FMT_LEGACY && !byp2) |=> (res_o <= LEG_MAX)); // R4
    AST_NEG_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ld2 && !byp2 && shifted < 0) |=> (res_o == '0)); // R6
endmodule

// File: rtl/ycc_rgb_matrix.sv
module ycc_rgb_matrix
    import ycc_rgb_pkg::*;
#(
    parameter int NUM_LAYERS = 2,
    parameter int COMP_W     = 10,
    parameter int LEG_W      = 8,
    localparam int LAYER_W   = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [COEF_W-1:0]   cfg_wdata,
    input  logic                pix_valid,
    input  logic [LAYER_W-1:0]  pix_layer,
    input  logic [COMP_W-1:0]   pix_c0,
    input  logic [COMP_W-1:0]   pix_c1,
    input  logic [COMP_W-1:0]   pix_c2,
    output logic                rgb_valid,
    output logic [COMP_W-1:0]   rgb_r,
    output logic [COMP_W-1:0]   rgb_g,
    output logic [COMP_W-1:0]   rgb_b
);
    localparam int ADJ_W = (((COMP_W + 1) > DIFF_W) ? (COMP_W + 1) : DIFF_W) + 1;

    logic [NUM_WORDS-1:0][COEF_W-1:0] coef_q;
    logic [NUM_LAYERS-1:0]            layer_en_q;
    fmt_e                             fmt_q;

    ycc_coef_regs #(.NUM_LAYERS(NUM_LAYERS)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .coef_o (coef_q),
        .en_o   (layer_en_q),
        .fmt_o  (fmt_q)
    );

    // stage 0: bias the inputs and pick bypass
    logic [NUM_CH-1:0][COMP_W-1:0] pix;
    logic [NUM_CH-1:0][ADJ_W-1:0]  adj;
    logic [NUM_CH-1:0][COMP_W-1:0] res;
    logic                          byp_sel;

    assign pix     = {pix_c2, pix_c1, pix_c0};
    assign byp_sel = ~layer_en_q[pix_layer];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_adj
        logic [DIFF_W-1:0] diff;
        assign diff = coef_q[k*ROW_WORDS + ROW_WORDS - 1][COEF_W-1 -: DIFF_W];
        always_comb begin
            if (fmt_q == FMT_EXTENDED) begin
                adj[k] = {{(ADJ_W-COMP_W){1'b0}}, pix[k]}
                       + {{(ADJ_W-DIFF_W){diff[DIFF_W-1]}}, diff};
            end else begin
                adj[k] = {{(ADJ_W-LEG_W){1'b0}}, pix[k][LEG_W-1:0]};
            end
        end
    end

    // valid pipeline, one bit per stage
    logic [2:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[1:0], pix_valid};
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        ycc_rgb_lane #(.COMP_W(COMP_W), .LEG_W(LEG_W), .ADJ_W(ADJ_W)) i_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld0    (pix_valid),
            .ld1    (vld_q[0]),
            .ld2    (vld_q[1]),
            .fmt_i  (fmt_q),
            .byp_i  (byp_sel),
            .pass_i (pix[ch]),
            .adj_i  (adj),
            .row_i  (coef_q[ch*ROW_WORDS +: ROW_WORDS]),
            .res_o  (res[ch])
        );
    end

    assign rgb_valid = vld_q[2];
    assign rgb_r     = res[0];
    assign rgb_g     = res[1];
    assign rgb_b     = res[2];

    // cycles since reset, saturating, so $past never reaches into reset
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (rgb_valid == $past(pix_valid, 3))); // R2
    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && rgb_valid && $past(pix_valid && byp_sel, 3))
        |-> (rgb_r == $past(pix_c0, 3) && rgb_g == $past(pix_c1, 3) && rgb_b == $past(pix_c2, 3))); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd0) |-> (!rgb_valid && rgb_r == '0 && rgb_g == '0 && rgb_b == '0)); // R1
endmodule

// File: tb/test_ycc_rgb_matrix.sv
module test_ycc_rgb_matrix;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [0:0]  pix_layer = '0;
    logic [9:0]  pix_c0 = '0, pix_c1 = '0, pix_c2 = '0;
    logic        rgb_valid;
    logic [9:0]  rgb_r, rgb_g, rgb_b;

    always #5 clk = ~clk;

    ycc_rgb_matrix i_ycc_rgb_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pix_valid(pix_valid), .pix_layer(pix_layer), .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2),
        .rgb_valid(rgb_valid), .rgb_r(rgb_r), .rgb_g(rgb_g), .rgb_b(rgb_b)
    );

    int checks = 0, errors = 0, cyc = 0, n_sent = 0, n_recv = 0;
    bit done = 0;
    logic [31:0] m_coef [12];
    logic [1:0]  m_en = '0;
    bit          m_ext = 0;
    int    exp_r [4096], exp_g [4096], exp_b [4096], exp_cyc [4096];
    string exp_tag [4096];

    always @(posedge clk) cyc <= cyc + 1;

    // reference arithmetic written from R4 and R5
    function automatic int chan(int n, int x0, int x1, int x2);
        int x [3];
        longint a, s, v, mx;
        x[0] = x0; x[1] = x1; x[2] = x2;
        s = 0;
        for (int k = 0; k < 3; k++) begin
            if (m_ext) a = longint'(x[k]) + longint'($signed(m_coef[4*k+3][31:16]));
            else       a = longint'(x[k] & 255);
            s = s + longint'($signed(m_coef[4*n+k])) * a;
        end
        if (m_ext) begin
            s  = s + longint'($signed(m_coef[4*n+3][15:0])) * 131072 + 65536;
            v  = s >>> 17;
            mx = 1023;
        end else begin
            s  = s + longint'($signed(m_coef[4*n+3])) + 512;
            v  = s >>> 10;
            mx = 255;
        end
        if (v < 0)  v = 0;
        if (v > mx) v = mx;
        return int'(v);
    endfunction

    task automatic step(input bit we, input int addr, input logic [31:0] data,
                        input bit v, input int lay, input int c0, input int c1, input int c2,
                        input string tag);
        @(negedge clk);
        if (v) begin
            if (!m_en[lay]) begin
                exp_r[n_sent] = c0; exp_g[n_sent] = c1; exp_b[n_sent] = c2;
            end else begin
                exp_r[n_sent] = chan(0, c0, c1, c2);
                exp_g[n_sent] = chan(1, c0, c1, c2);
                exp_b[n_sent] = chan(2, c0, c1, c2);
            end
            exp_cyc[n_sent] = cyc;
            exp_tag[n_sent] = tag;
            n_sent++;
        end
        if (we) begin
            if (addr < 12) m_coef[addr] = data;
            else if (addr == 12) begin m_en = data[1:0]; m_ext = data[31]; end
        end
        cfg_we = we; cfg_addr = addr[3:0]; cfg_wdata = data;
        pix_valid = v; pix_layer = lay[0];
        pix_c0 = c0[9:0]; pix_c1 = c1[9:0]; pix_c2 = c2[9:0];
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        step(1, addr, data, 0, 0, 0, 0, 0, "");
    endtask

    task automatic pix(input int lay, input int c0, input int c1, input int c2, input string tag);
        step(0, 0, 32'h0, 1, lay, c0, c1, c2, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 32'h0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic load_set(input logic [31:0] w [12]);
        for (int i = 0; i < 12; i++) wr(i, w[i]);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // scoreboard: order, values and latency
    always @(negedge clk) begin
        if (rst_n && !done && rgb_valid) begin
            checks++;
            if (n_recv >= n_sent) begin
                errors++;
                $display("FAIL R2: output valid with no pixel pending, actual 1 expected 0");
            end else begin
                if (rgb_r !== exp_r[n_recv][9:0] || rgb_g !== exp_g[n_recv][9:0] ||
                    rgb_b !== exp_b[n_recv][9:0] || cyc != exp_cyc[n_recv] + 3) begin
                    errors++;
                    $display("FAIL %s R2: pixel %0d actual %0d/%0d/%0d at %0d expected %0d/%0d/%0d at %0d",
                             exp_tag[n_recv], n_recv, rgb_r, rgb_g, rgb_b, cyc,
                             exp_r[n_recv], exp_g[n_recv], exp_b[n_recv], exp_cyc[n_recv] + 3);
                end
                n_recv++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: run incomplete, actual %0d outputs expected %0d", n_recv, n_sent);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] s [12];
        logic [31:0] t [12];
        for (int i = 0; i < 12; i++) m_coef[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: quiet outputs right after reset
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            checks++;
            if (rgb_valid !== 1'b0 || rgb_r !== '0 || rgb_g !== '0 || rgb_b !== '0) begin
                errors++;
                $display("FAIL R1: reset outputs actual %b/%0d/%0d/%0d expected 0/0/0/0",
                         rgb_valid, rgb_r, rgb_g, rgb_b);
            end
        end
        pix(0, 50, 60, 700, "R1 R7 enables clear after reset");
        wr(12, 32'h0000_0001);
        pix(0, 100, 200, 300, "R1 coefficients zero after reset");

        // R4 R6: mixed-sign legacy matrix, upper input bits set on c2
        s = '{32'h0000_04A0, 32'h0, 32'h0000_0660, 32'hFFFC_8000,
              32'h0000_04A0, 32'hFFFF_FE70, 32'hFFFF_FCC0, 32'h0002_1C00,
              32'h0000_04A0, 32'h0000_0810, 32'h0, 32'hFFFB_AC00};
        load_set(s);
        for (int v = 0; v < 256; v++) pix(0, v, 255 - v, ((v * 7) & 255) | 256, "R4 R6 legacy sweep");

        // R3: columns 1 and 2 swapped with inputs swapped
        t = s;
        for (int r = 0; r < 3; r++) begin t[4*r+1] = s[4*r+2]; t[4*r+2] = s[4*r+1]; end
        load_set(t);
        for (int v = 0; v < 256; v++) pix(0, v, (v * 7) & 255, 255 - v, "R3 swapped columns");

        // R4 R6: half-up rounding and upper clamp
        s = '{32'h400, 32'h0, 32'h0, 32'h200,
              32'h0, 32'h400, 32'h0, 32'h1FF,
              32'h0, 32'h0, 32'h400, 32'hFFFF_FE00};
        load_set(s);
        for (int v = 0; v < 256; v++) pix(0, v, v, v, "R4 R6 rounding");

        // R3: writes above the control word are ignored
        wr(13, 32'hFFFF_FFFF);
        wr(15, 32'h8000_0000);
        for (int v = 0; v < 8; v++) pix(0, v * 30, v * 20, v * 10, "R3 unused address");

        // R5 R6: extended format with input biases
        s = '{32'h0002_5400, 32'h0, 32'h0003_3100, 32'hFFC0_0000,
              32'h0002_5400, 32'hFFFF_3700, 32'hFFFE_6000, 32'hFE00_0000,
              32'h0002_5400, 32'h0004_0900, 32'h0, 32'hFE00_0000};
        load_set(s);
        wr(12, 32'h8000_0003);
        for (int v = 0; v < 1024; v++) pix(v & 1, v, 1023 - v, (v * 37) % 1024, "R5 R6 extended sweep");

        // R5 R6: extended constants and fractional factor
        s = '{32'h0002_0000, 32'h0, 32'h0, 32'h0000_0010,
              32'h0, 32'h0002_0000, 32'h0, 32'h0000_FFF0,
              32'h0, 32'h0, 32'h0001_8000, 32'h0};
        load_set(s);
        for (int v = 0; v < 256; v++) pix(0, v * 4 + 3, v * 4, v * 4 + 1, "R5 R6 extended constant");

        // R7: only layer 0 converts
        wr(12, 32'h8000_0001);
        for (int v = 0; v < 64; v++) pix(v & 1, v * 16, 1000 - v, v * 3, "R7 per-layer bypass");

        // R8: write on the same cycle as a pixel, then a stream with interleaved writes
        pix(0, 500, 400, 300, "R8 in flight");
        step(1, 0, 32'h0004_0000, 1, 0, 500, 400, 300, "R8 same-cycle write");
        pix(0, 500, 400, 300, "R8 next pixel");
        for (int v = 0; v < 20; v++) begin
            step(1, 4 * (v % 3), 32'h0001_0000 + 32'(v) * 32'h800, 1, 0, v * 40, v * 30, v * 20, "R8 interleaved");
            pix(0, v * 50, v * 10, v * 5, "R8 interleaved");
        end

        // R2: gaps preserved
        pix(1, 11, 22, 33, "R2 gap");
        idle(2);
        pix(0, 44, 55, 66, "R2 gap");
        idle(1);
        pix(1, 77, 88, 99, "R2 gap");
        idle(8);

        done = 1;
        checks++;
        if (n_recv != n_sent) begin
            errors++;
            $display("FAIL R2: output count actual %0d expected %0d", n_recv, n_sent);
        end
        summary();
        $finish;
    end
endmodule